// File: doc/BRIEF.md
# Triggered ADC Scan Sequencer

This block steers an external successive-approximation converter around a group of four analog channels. A CPU-side bus writes an enable bit and a start bit together through one control strobe, and picks a channel group through a second strobe. Once both bits are set, the block waits for a pulse on the hardware trigger input. Each trigger starts a scan at the first channel of the selected group. The block then keeps stepping through the group in a loop: every finished conversion is captured and announced, and the next channel starts straight away.

The converter core sees a one-cycle start pulse together with a channel number, and a one-cycle abort pulse. It answers with a done strobe and a result word. The block discards any conversion that is cut short. A restarting event (a trigger, a group write, or a repeated start write) drops the partial result and begins again at the first channel. Clearing start parks the block in standby with the converter still powered. Clearing enable takes it to the stopped state.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is stopped, conv_start, conv_abort and irq_eoc are 0, and result is 0.
- R2: A control write with enable=1 and start=0 moves the block to conversion standby. In the stopped state and in conversion standby, hw_trig starts no conversion.
- R3: start=1 takes effect only when enable was already 1 before the write, and it moves the block to trigger wait. No conversion begins in trigger wait until hw_trig is pulsed.
- R4: hw_trig in trigger wait produces a conv_start pulse in the next cycle, with conv_chan = group*4 + 0. The channel is 3 bits wide: the group value (0 or 1) is bit 2 and the scan index is bits 1:0.
- R5: conv_done during a running scan copies conv_data into result and pulses irq_eoc for one cycle, in the cycle after the strobe. In that same cycle conv_start issues the next scan index, wrapping from index 3 to index 0. With a converter latency of L cycles, irq_eoc follows its conv_start by L+1 cycles.
- R6: hw_trig during a conversion gives conv_abort and conv_start together in the next cycle, and the scan restarts at index 0 of the current group.
- R7: A group write during a conversion, even one that repeats the current value, aborts the conversion and restarts at index 0 of the newly written group. A group write outside a conversion only stores the value.
- R8: A control write of enable=1, start=1 during a conversion aborts it and restarts at index 0.
- R9: A control write of start=0 during a conversion gives conv_abort without a new conv_start and returns the block to conversion standby, where hw_trig is ignored.
- R10: A control write of enable=0 returns the block to the stopped state. While stopped, writes of start=1 are ignored and no conversion can begin.
- R11: An aborted conversion never changes result and never pulses irq_eoc. When hw_trig and conv_done arrive in the same cycle, the trigger wins: the result is dropped and the scan restarts at index 0.
- R12: A conv_done strobe that arrives when no scan is running changes neither result nor irq_eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Enable bit value written with ctrl_we |
| ctrl_start | input | 1 | Start bit value written with ctrl_we |
| grp_we | input | 1 | Group select write strobe |
| grp_wdata | input | 1 | Group select value |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result, valid with conv_done |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 3 | Channel number, valid with conv_start |
| conv_abort | output | 1 | Abort pulse to the converter |
| result | output | 10 | Last accepted conversion result |
| irq_eoc | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The assertions assume that the converter never raises conv_done earlier than two cycles after a conv_start, so that interrupts cannot come back to back. They also assume that conv_done and the other inputs are 0 while reset is held. The bench models the converter with a fixed five-cycle latency and cancels its work when it sees an abort. Every bus write and trigger is driven one cycle wide, shortly after the falling edge. The only deliberate overlap is a trigger placed in the exact cycle of a done strobe. Spurious done strobes are injected only while no scan is running.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_ARMED = 2'd2,
    MODE_RUN   = 2'd3
  } scan_mode_e;

  // channel number = group in the upper bits, scan index in the lower bits
  function automatic logic [7:0] chan_of(input logic [7:0] grp,
                                         input logic [7:0] idx,
                                         input int unsigned idx_w);
    return (grp << idx_w) | idx;
  endfunction

  // next scan index with wrap at the group length
  function automatic logic [7:0] idx_step(input logic [7:0] idx,
                                          input int unsigned len);
    if (32'(idx) + 32'd1 >= len) return 8'd0;
    return idx + 8'd1;
  endfunction

endpackage

// File: rtl/scan_mode_fsm.sv
module scan_mode_fsm
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       ctrl_enable,
  input  logic       ctrl_start,
  input  logic       grp_we,
  input  logic       hw_trig,
  input  logic       conv_done,
  output scan_mode_e mode,
  output logic       evt_restart,
  output logic       evt_abort,
  output logic       evt_accept
);

  scan_mode_e mode_q, mode_nxt;
  logic       running;

  always_comb begin
    mode_nxt    = mode_q;
    evt_restart = 1'b0;
    evt_abort   = 1'b0;
    evt_accept  = 1'b0;
    running     = (mode_q == MODE_RUN);
    if (ctrl_we) begin
      if (!ctrl_enable) begin
        mode_nxt  = MODE_OFF;
        evt_abort = running;
      end else if (!ctrl_start) begin
        mode_nxt  = MODE_IDLE;
        evt_abort = running;
      end else begin
        case (mode_q)
          MODE_OFF:   mode_nxt = MODE_IDLE;   // start ignored, enable taken
          MODE_IDLE:  mode_nxt = MODE_ARMED;
          MODE_ARMED: mode_nxt = MODE_ARMED;
          MODE_RUN: begin
            evt_restart = 1'b1;
            evt_abort   = 1'b1;
          end
          default:    mode_nxt = MODE_OFF;
        endcase
      end
    end else if (running && (hw_trig || grp_we)) begin
      evt_restart = 1'b1;
      evt_abort   = 1'b1;
    end else if ((mode_q == MODE_ARMED) && hw_trig) begin
      evt_restart = 1'b1;
      mode_nxt    = MODE_RUN;
    end else if (running && conv_done) begin
      evt_accept = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_nxt;
  end

  assign mode = mode_q;

endmodule

// File: rtl/scan_pointer.sv
module scan_pointer
  import adc_scan_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SCAN_LEN = 4,
  localparam int IDX_W   = $clog2(SCAN_LEN),
  localparam int GRP_W   = CH_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_we,
  input  logic [GRP_W-1:0] grp_wdata,
  input  logic             evt_restart,
  input  logic             evt_accept,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan
);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [GRP_W-1:0] grp_q, grp_nxt;
  logic [CH_W-1:0]  chan_nxt;

  always_comb begin
    grp_nxt = grp_we ? grp_wdata : grp_q;
    if (evt_restart)     idx_nxt = '0;
    else if (evt_accept) idx_nxt = IDX_W'(idx_step(8'(idx_q), SCAN_LEN));
    else                 idx_nxt = idx_q;
    chan_nxt = CH_W'(chan_of(8'(grp_nxt), 8'(idx_nxt), IDX_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      grp_q      <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      idx_q      <= idx_nxt;
      grp_q      <= grp_nxt;
      conv_start <= evt_restart | evt_accept;
      conv_chan  <= chan_nxt;
    end
  end

endmodule

// File: rtl/result_capture.sv
module result_capture #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_accept,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result,
  output logic             irq_eoc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      irq_eoc <= 1'b0;
    end else begin
      irq_eoc <= evt_accept;
      if (evt_accept) result <= conv_data;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SCAN_LEN = 4,
  parameter int RES_W    = 10,
  localparam int IDX_W   = $clog2(SCAN_LEN),
  localparam int GRP_W   = CH_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_enable,
  input  logic             ctrl_start,
  input  logic             grp_we,
  input  logic [GRP_W-1:0] grp_wdata,
  input  logic             hw_trig,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_abort,
  output logic [RES_W-1:0] result,
  output logic             irq_eoc
);

  // named internal events, visible to the bound checker
  scan_mode_e mode;
  logic       evt_restart;
  logic       evt_abort;
  logic       evt_accept;

  scan_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_enable (ctrl_enable),
    .ctrl_start  (ctrl_start),
    .grp_we      (grp_we),
    .hw_trig     (hw_trig),
    .conv_done   (conv_done),
    .mode        (mode),
    .evt_restart (evt_restart),
    .evt_abort   (evt_abort),
    .evt_accept  (evt_accept)
  );

  scan_pointer #(.CH_W(CH_W), .SCAN_LEN(SCAN_LEN)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_we      (grp_we),
    .grp_wdata   (grp_wdata),
    .evt_restart (evt_restart),
    .evt_accept  (evt_accept),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan)
  );

  result_capture #(.RES_W(RES_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_accept (evt_accept),
    .conv_data  (conv_data),
    .result     (result),
    .irq_eoc    (irq_eoc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) conv_abort <= 1'b0;
    else        conv_abort <= evt_abort;
  end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             hw_trig,
  input logic             conv_done,
  input logic             conv_start,
  input logic             conv_abort,
  input logic [RES_W-1:0] result,
  input logic             irq_eoc,
  input scan_mode_e       mode
);

  p_irq_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoc |-> $past(conv_done));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoc |=> !irq_eoc);

  p_trig_beats_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && hw_trig && conv_done && !ctrl_we)
      |=> (!irq_eoc && conv_abort && conv_start));

  p_result_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_eoc |-> $stable(result));

  p_abort_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> $past(mode) == MODE_RUN);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> !conv_start);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> !conv_start);

  p_armed_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ARMED && hw_trig && !ctrl_we) |=> (conv_start && !conv_abort));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .hw_trig    (hw_trig),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .conv_abort (conv_abort),
  .result     (result),
  .irq_eoc    (irq_eoc),
  .mode       (mode)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_start = 1'b0;
  logic       grp_we = 1'b0;
  logic [0:0] grp_wdata = 1'b0;
  logic       hw_trig = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       conv_start, conv_abort, irq_eoc;
  logic [2:0] conv_chan;
  logic [9:0] result;

  int n_checks = 0, n_fail = 0;
  int irq_cnt = 0, start_cnt = 0, cyc = 0, last_start_cyc = 0;
  logic [0:0] exp_grp = 1'b0;
  logic [1:0] exp_idx = 2'd0;
  bit   pending = 1'b0;
  bit   spur_req = 1'b0;
  bit   busy = 1'b0;
  int   cnt = 0;
  logic [2:0] m_ch = '0;
  logic [6:0] m_seq = '0;
  logic [9:0] last_done = '0;

  always #2.5 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_start(ctrl_start), .grp_we(grp_we), .grp_wdata(grp_wdata),
    .hw_trig(hw_trig), .conv_done(conv_done), .conv_data(conv_data),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_abort(conv_abort),
    .result(result), .irq_eoc(irq_eoc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor and converter model, both at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq_eoc) begin
        irq_cnt++;
        chk(result == last_done, "R5", "captured result", int'(result), int'(last_done));
        chk(cyc - last_start_cyc == LAT + 1, "R5", "irq latency", cyc - last_start_cyc, LAT + 1);
        chk(conv_start == 1'b1, "R5", "next channel starts with irq", int'(conv_start), 1);
      end
      if (conv_start) begin
        start_cnt++;
        last_start_cyc = cyc;
        if (pending) begin exp_idx = 2'd0; pending = 1'b0; end
        chk(conv_chan == {exp_grp, exp_idx}, "R4", "scan channel order",
            int'(conv_chan), int'({exp_grp, exp_idx}));
        exp_idx = exp_idx + 2'd1;
      end
    end
    conv_done = 1'b0;
    if (!rst_n) busy = 1'b0;
    else begin
      if (conv_abort) busy = 1'b0;
      if (conv_start) begin busy = 1'b1; cnt = LAT; m_ch = conv_chan; end
      else if (busy) begin
        cnt--;
        if (cnt == 0) begin
          busy = 1'b0;
          m_seq = m_seq + 7'd1;
          conv_data = {m_ch, m_seq};
          last_done = conv_data;
          conv_done = 1'b1;
        end
      end
      if (spur_req) begin conv_done = 1'b1; conv_data = 10'h2AA; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ctrl_write(input bit en, input bit st);
    ctrl_we = 1'b1; ctrl_enable = en; ctrl_start = st;
    tick(1);
    ctrl_we = 1'b0;
  endtask

  task automatic trig(input bit expect_restart);
    if (expect_restart) pending = 1'b1;
    hw_trig = 1'b1;
    tick(1);
    hw_trig = 1'b0;
  endtask

  task automatic grp_write(input bit g, input bit expect_restart);
    if (expect_restart) pending = 1'b1;
    exp_grp = g;
    grp_we = 1'b1; grp_wdata = g;
    tick(1);
    grp_we = 1'b0;
  endtask

  task automatic wait_irqs(input int n);
    int target;
    target = irq_cnt + n;
    for (int i = 0; i < 400 && irq_cnt < target; i++) tick(1);
  endtask

  // land two cycles into a conversion
  task automatic mid_conv();
    for (int i = 0; i < 40 && !conv_start; i++) tick(1);
    tick(2);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s0, i0;
    logic [9:0] r0;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(conv_start == 0 && conv_abort == 0, "R1", "pulses after reset", int'(conv_start), 0);
    chk(irq_eoc == 0, "R1", "irq after reset", int'(irq_eoc), 0);
    chk(result == 0, "R1", "result after reset", int'(result), 0);

    // R3 / R10: start with enable low is ignored
    ctrl_write(1'b0, 1'b1);
    s0 = start_cnt;
    trig(1'b0); tick(10);
    chk(start_cnt == s0, "R10", "start while disabled", start_cnt - s0, 0);

    // R2: conversion standby ignores triggers
    ctrl_write(1'b1, 1'b0);
    trig(1'b0); tick(10);
    chk(start_cnt == s0, "R2", "trigger in standby", start_cnt - s0, 0);

    // R10: enable and start together from stop: start ignored
    ctrl_write(1'b0, 1'b0);
    ctrl_write(1'b1, 1'b1);
    trig(1'b0); tick(10);
    chk(start_cnt == s0, "R10", "start in same write as enable", start_cnt - s0, 0);

    // R3: armed, nothing happens without trigger
    ctrl_write(1'b1, 1'b1);
    tick(12);
    chk(start_cnt == s0, "R3", "no conversion before trigger", start_cnt - s0, 0);

    // R7: group write outside conversion only stores
    grp_write(1'b0, 1'b0);
    tick(4);
    chk(start_cnt == s0 && conv_abort == 0, "R7", "group write while armed", start_cnt - s0, 0);

    // R4 / R5: trigger, two full passes
    trig(1'b1);
    chk(conv_start == 1 && conv_chan == 3'd0, "R4", "first channel after trigger", int'(conv_chan), 0);
    i0 = irq_cnt;
    wait_irqs(8);
    chk(irq_cnt - i0 == 8, "R5", "eight results in two passes", irq_cnt - i0, 8);

    // R6: trigger mid conversion
    mid_conv();
    i0 = irq_cnt; r0 = result;
    trig(1'b1);
    chk(conv_abort == 1 && conv_start == 1, "R6", "abort with restart", int'(conv_abort), 1);
    chk(conv_chan == 3'd0, "R6", "restart channel", int'(conv_chan), 0);
    chk(irq_cnt == i0 && result == r0, "R11", "no result from abort", int'(result), int'(r0));

    // R7: new group mid conversion
    wait_irqs(2); mid_conv();
    grp_write(1'b1, 1'b1);
    chk(conv_abort == 1 && conv_chan == 3'd4, "R7", "restart in new group", int'(conv_chan), 4);
    wait_irqs(4);
    mid_conv();
    grp_write(1'b1, 1'b1);
    chk(conv_abort == 1 && conv_chan == 3'd4, "R7", "same-value group write", int'(conv_chan), 4);

    // R8: start rewrite mid conversion
    wait_irqs(1); mid_conv();
    pending = 1'b1;
    ctrl_write(1'b1, 1'b1);
    chk(conv_abort == 1 && conv_start == 1 && conv_chan == 3'd4, "R8", "start rewrite restart",
        int'(conv_chan), 4);

    // sweep: each group, each scan position, trigger restart
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 4; k++) begin
        grp_write(g[0], 1'b1);
        wait_irqs(k); mid_conv();
        trig(1'b1);
        chk(conv_abort == 1 && conv_chan == 3'(g * 4), "R6", "sweep restart channel",
            int'(conv_chan), g * 4);
      end
    end

    // R11: trigger in the same cycle as done
    for (int i = 0; i < 40 && !conv_done; i++) tick(1);
    i0 = irq_cnt; r0 = result;
    pending = 1'b1;
    hw_trig = 1'b1;
    tick(1);
    hw_trig = 1'b0;
    chk(irq_eoc == 0 && result == r0, "R11", "trigger beats done", int'(result), int'(r0));
    chk(conv_abort == 1 && conv_chan == 3'd4, "R11", "restart after collision", int'(conv_chan), 4);
    tick(1);
    chk(irq_cnt == i0, "R11", "collision irq count", irq_cnt - i0, 0);

    // R9: clear start mid conversion
    wait_irqs(1); mid_conv();
    s0 = start_cnt; i0 = irq_cnt;
    ctrl_write(1'b1, 1'b0);
    chk(conv_abort == 1 && conv_start == 0, "R9", "abort without restart", int'(conv_start), 0);
    trig(1'b0); tick(15);
    chk(start_cnt == s0 && irq_cnt == i0, "R9", "standby ignores trigger", start_cnt - s0, 0);

    // R12: spurious done while idle
    r0 = result;
    spur_req = 1'b1; tick(1); spur_req = 1'b0; tick(2);
    chk(irq_cnt == i0 && result == r0, "R12", "stray done ignored", int'(result), int'(r0));

    // R10: stop, start ignored, then re-arm in group 1
    ctrl_write(1'b0, 1'b0);
    ctrl_write(1'b0, 1'b1);
    trig(1'b0); tick(10);
    chk(start_cnt == s0, "R10", "stopped ignores start and trigger", start_cnt - s0, 0);
    ctrl_write(1'b1, 1'b0);
    ctrl_write(1'b1, 1'b1);
    trig(1'b1);
    chk(conv_start == 1 && conv_chan == 3'd4, "R4", "group 1 scan start", int'(conv_chan), 4);
    i0 = irq_cnt;
    wait_irqs(5);
    chk(irq_cnt - i0 == 5, "R5", "wrap past index 3", irq_cnt - i0, 5);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule